// File: doc/BRIEF.md
# PHY Bring-Up Sequencer

This block brings an Ethernet PHY from an unknown state to a negotiated link through a management-bus master. A single `start` pulse launches a fixed programme. First a soft reset is written to the control register, and the control register is then read back until its reset bit clears. Next the ability advertisement register is loaded with all four 10/100 modes, and autonegotiation is enabled and restarted. The status register is polled until negotiation completes, and is then read once more to derive the link speed and duplex.

Every register access is a request on a simple command port: a one-cycle `mdio_req` strobe together with the direction, register number, PHY address and write data. The block then waits for the master's one-cycle `mdio_ack`, which returns the read data. Both polling loops are bounded. If either loop runs out of attempts, the block stops with its own error code. Each run ends with exactly one `done` pulse, and at that point the error code and the link mode are valid. They then hold until the next run starts.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset, `done`, `mdio_req`, `speed_100`, `full_duplex` are 0 and `err_code` is 0.
- R2: A `start` pulse while idle makes the first transaction a write of 0x8000 to register 0, addressed to PHY address `PHY_ADDR`.
- R3: Register 0 is read until its bit 15 reads 0, with a wait of `POLL_GAP` cycles between reads and no more than `RESET_TRIES` reads. If every allowed read shows bit 15 set, the run ends with `err_code` = 1 and no further transactions are issued.
- R4: Once reset clears, the block writes 0x01E1 to register 4 and then 0x1200 to register 0, in that order. These are the only writes after the reset write.
- R5: Register 1 is then read until its bit 5 reads 1, with no more than `ANEG_TRIES` reads. If that limit is exhausted, the run ends with `err_code` = 2.
- R6: After completion is seen, register 1 is read once more. `speed_100` becomes 1 if bit 14 or bit 13 of that word is set, and 0 otherwise.
- R7: `full_duplex` becomes 1 if bit 14 or bit 12 of that final status word is set, and 0 otherwise.
- R8: Every run ends with exactly one single-cycle `done` pulse. `err_code` is 0 on success, and on either error `speed_100` and `full_duplex` are 0.
- R9: Each transaction raises `mdio_req` for exactly one cycle. No new request is raised until the previous one has been acknowledged.
- R10: `start` has no effect while a run is in progress: the run completes unchanged, with one `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a bring-up run when idle |
| done | output | 1 | One-cycle pulse at the end of a run |
| err_code | output | 2 | 0 success, 1 reset poll timeout, 2 negotiation timeout |
| speed_100 | output | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_duplex | output | 1 | 1 = full duplex, 0 = half duplex |
| mdio_req | output | 1 | Transaction strobe to the management master |
| mdio_write | output | 1 | 1 = write, 0 = read |
| mdio_phy_addr | output | 5 | PHY address of the transaction |
| mdio_reg_addr | output | 5 | Register number of the transaction |
| mdio_wdata | output | 16 | Write data |
| mdio_ack | input | 1 | Master completion pulse |
| mdio_rdata | input | 16 | Read data, valid with `mdio_ack` |

## Verification
The bench builds the block with `RESET_TRIES` = 4, `ANEG_TRIES` = 5, `POLL_GAP` = 2 and `PHY_ADDR` = 3. The small poll limits make it cheap to reach both timeout exits. They also make it cheap to reach the case where the last allowed read succeeds. The short gap keeps even the longest runs within a few hundred cycles. A non-zero PHY address shows that the configured address really reaches the bus.

// File: rtl/phy_bringup_pkg.sv
package phy_bringup_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RST_WR,
        S_RST_RD,
        S_RST_GAP,
        S_ADV_WR,
        S_ANEG_WR,
        S_ANEG_RD,
        S_ANEG_GAP,
        S_STAT_RD,
        S_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {
        ERR_NONE     = 2'd0,
        ERR_RST_TMO  = 2'd1,
        ERR_ANEG_TMO = 2'd2
    } seq_err_t;

    localparam logic [4:0]  REG_CTRL        = 5'd0;
    localparam logic [4:0]  REG_STAT        = 5'd1;
    localparam logic [4:0]  REG_ADV         = 5'd4;
    localparam logic [15:0] CTRL_RESET_WORD = 16'h8000;
    localparam logic [15:0] ADV_WORD        = 16'h01E1;
    localparam logic [15:0] ANEG_GO_WORD    = 16'h1200;

    localparam int CTRL_RESET_BIT = 15;
    localparam int STAT_DONE_BIT  = 5;
    localparam int STAT_F100_BIT  = 14;
    localparam int STAT_H100_BIT  = 13;
    localparam int STAT_F10_BIT   = 12;

    typedef struct packed {
        logic        write;
        logic [4:0]  reg_addr;
        logic [15:0] wdata;
    } mgmt_cmd_t;

    typedef struct packed {
        logic speed_100;
        logic full_duplex;
    } link_mode_t;

    function automatic link_mode_t decode_status(input logic [15:0] w);
        link_mode_t m;
        m.speed_100   = w[STAT_F100_BIT] | w[STAT_H100_BIT];
        m.full_duplex = w[STAT_F100_BIT] | w[STAT_F10_BIT];
        return m;
    endfunction

    function automatic logic is_txn_state(input seq_state_t s);
        return (s == S_RST_WR) || (s == S_RST_RD) || (s == S_ADV_WR) ||
               (s == S_ANEG_WR) || (s == S_ANEG_RD) || (s == S_STAT_RD);
    endfunction

endpackage

// File: rtl/pbs_wait_timer.sv
module pbs_wait_timer #(
    parameter int GAP = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CW = (GAP < 1) ? 1 : $clog2(GAP + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(GAP);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= LOAD_VAL;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/pbs_try_counter.sv
module pbs_try_counter #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic final_try
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] fails;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            fails <= '0;
        end else if (inc && (fails != LAST)) begin
            fails <= fails + 1'b1;
        end
    end

    // The read in flight is the last one allowed.
    assign final_try = (fails == LAST);
endmodule

// File: rtl/pbs_cmd_gen.sv
module pbs_cmd_gen
    import phy_bringup_pkg::*;
(
    input  seq_state_t state,
    output mgmt_cmd_t  cmd
);
    always_comb begin
        cmd = '{write: 1'b0, reg_addr: REG_CTRL, wdata: 16'h0000};
        unique case (state)
            S_RST_WR:  cmd = '{write: 1'b1, reg_addr: REG_CTRL, wdata: CTRL_RESET_WORD};
            S_RST_RD:  cmd = '{write: 1'b0, reg_addr: REG_CTRL, wdata: 16'h0000};
            S_ADV_WR:  cmd = '{write: 1'b1, reg_addr: REG_ADV,  wdata: ADV_WORD};
            S_ANEG_WR: cmd = '{write: 1'b1, reg_addr: REG_CTRL, wdata: ANEG_GO_WORD};
            S_ANEG_RD: cmd = '{write: 1'b0, reg_addr: REG_STAT, wdata: 16'h0000};
            S_STAT_RD: cmd = '{write: 1'b0, reg_addr: REG_STAT, wdata: 16'h0000};
            default:   cmd = '{write: 1'b0, reg_addr: REG_CTRL, wdata: 16'h0000};
        endcase
    end
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
    import phy_bringup_pkg::*;
#(
    parameter int         POLL_GAP    = 4,
    parameter int         RESET_TRIES = 10,
    parameter int         ANEG_TRIES  = 100,
    parameter logic [4:0] PHY_ADDR    = 5'd1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    output logic        done,
    output logic [1:0]  err_code,
    output logic        speed_100,
    output logic        full_duplex,
    output logic        mdio_req,
    output logic        mdio_write,
    output logic [4:0]  mdio_phy_addr,
    output logic [4:0]  mdio_reg_addr,
    output logic [15:0] mdio_wdata,
    input  logic        mdio_ack,
    input  logic [15:0] mdio_rdata
);
    seq_state_t state, state_nx;
    seq_err_t   err_q, err_nx;
    link_mode_t mode_q, mode_nx;
    mgmt_cmd_t  cmd;
    logic       issued;
    logic       got;
    logic       in_txn;
    logic       tmr_load, tmr_expired;
    logic       rst_clr, rst_inc, rst_final;
    logic       an_clr, an_inc, an_final;

    pbs_cmd_gen u_cmd (
        .state (state),
        .cmd   (cmd)
    );

    pbs_wait_timer #(.GAP(POLL_GAP)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .expired (tmr_expired)
    );

    pbs_try_counter #(.LIMIT(RESET_TRIES)) u_rst_tries (
        .clk       (clk),
        .rst       (rst),
        .clr       (rst_clr),
        .inc       (rst_inc),
        .final_try (rst_final)
    );

    pbs_try_counter #(.LIMIT(ANEG_TRIES)) u_an_tries (
        .clk       (clk),
        .rst       (rst),
        .clr       (an_clr),
        .inc       (an_inc),
        .final_try (an_final)
    );

    assign in_txn = is_txn_state(state);
    assign got    = in_txn && issued && mdio_ack;

    always_comb begin
        state_nx = state;
        err_nx   = err_q;
        mode_nx  = mode_q;
        tmr_load = 1'b0;
        rst_clr  = 1'b0;
        rst_inc  = 1'b0;
        an_clr   = 1'b0;
        an_inc   = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    state_nx = S_RST_WR;
                    err_nx   = ERR_NONE;
                    mode_nx  = '0;
                    rst_clr  = 1'b1;
                    an_clr   = 1'b1;
                end
            end
            S_RST_WR: if (got) state_nx = S_RST_RD;
            S_RST_RD: begin
                if (got) begin
                    if (!mdio_rdata[CTRL_RESET_BIT]) begin
                        state_nx = S_ADV_WR;
                    end else if (rst_final) begin
                        state_nx = S_FINISH;
                        err_nx   = ERR_RST_TMO;
                    end else begin
                        state_nx = S_RST_GAP;
                        rst_inc  = 1'b1;
                        tmr_load = 1'b1;
                    end
                end
            end
            S_RST_GAP:  if (tmr_expired) state_nx = S_RST_RD;
            S_ADV_WR:   if (got) state_nx = S_ANEG_WR;
            S_ANEG_WR:  if (got) state_nx = S_ANEG_RD;
            S_ANEG_RD: begin
                if (got) begin
                    if (mdio_rdata[STAT_DONE_BIT]) begin
                        state_nx = S_STAT_RD;
                    end else if (an_final) begin
                        state_nx = S_FINISH;
                        err_nx   = ERR_ANEG_TMO;
                    end else begin
                        state_nx = S_ANEG_GAP;
                        an_inc   = 1'b1;
                        tmr_load = 1'b1;
                    end
                end
            end
            S_ANEG_GAP: if (tmr_expired) state_nx = S_ANEG_RD;
            S_STAT_RD: begin
                if (got) begin
                    state_nx = S_FINISH;
                    mode_nx  = decode_status(mdio_rdata);
                end
            end
            S_FINISH: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            err_q  <= ERR_NONE;
            mode_q <= '0;
            issued <= 1'b0;
        end else begin
            state  <= state_nx;
            err_q  <= err_nx;
            mode_q <= mode_nx;
            if (state_nx != state) begin
                issued <= 1'b0;
            end else if (mdio_req) begin
                issued <= 1'b1;
            end
        end
    end

    assign mdio_req      = in_txn && !issued;
    assign mdio_write    = cmd.write;
    assign mdio_reg_addr = cmd.reg_addr;
    assign mdio_wdata    = cmd.wdata;
    assign mdio_phy_addr = PHY_ADDR;
    assign done          = (state == S_FINISH);
    assign err_code      = err_q;
    assign speed_100     = mode_q.speed_100;
    assign full_duplex   = mode_q.full_duplex;
endmodule

// File: rtl/phy_bringup_seq_chk.sv
module phy_bringup_seq_chk #(
    parameter int RESET_TRIES = 10,
    parameter int ANEG_TRIES  = 100
) (
    input logic        clk,
    input logic        rst,
    input logic        done,
    input logic [1:0]  err_code,
    input logic        speed_100,
    input logic        full_duplex,
    input logic        mdio_req,
    input logic        mdio_write,
    input logic [4:0]  mdio_reg_addr,
    input logic [15:0] mdio_wdata,
    input logic        mdio_ack
);
    logic       outstanding;
    logic [7:0] rd0_cnt;
    logic [7:0] rd1_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding <= 1'b0;
            rd0_cnt     <= '0;
            rd1_cnt     <= '0;
        end else begin
            if (mdio_req) outstanding <= 1'b1;
            else if (mdio_ack) outstanding <= 1'b0;
            if (done) begin
                rd0_cnt <= '0;
                rd1_cnt <= '0;
            end else if (mdio_req && !mdio_write) begin
                if (mdio_reg_addr == 5'd0) rd0_cnt <= rd0_cnt + 1'b1;
                if (mdio_reg_addr == 5'd1) rd1_cnt <= rd1_cnt + 1'b1;
            end
        end
    end

    a_r9_single_strobe: assert property (@(posedge clk) disable iff (rst)
        mdio_req |=> !mdio_req);

    a_r9_no_overlap: assert property (@(posedge clk) disable iff (rst)
        mdio_req |-> !outstanding);

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_err_code_legal: assert property (@(posedge clk) disable iff (rst)
        done |-> (err_code != 2'd3));

    a_r8_error_clears_mode: assert property (@(posedge clk) disable iff (rst)
        (done && err_code != 2'd0) |-> (!speed_100 && !full_duplex));

    a_r4_ctrl_write_words: assert property (@(posedge clk) disable iff (rst)
        (mdio_req && mdio_write && mdio_reg_addr == 5'd0) |->
            (mdio_wdata == 16'h8000 || mdio_wdata == 16'h1200));

    a_r4_adv_write_word: assert property (@(posedge clk) disable iff (rst)
        (mdio_req && mdio_write && mdio_reg_addr == 5'd4) |-> (mdio_wdata == 16'h01E1));

    a_r3_reset_poll_bound: assert property (@(posedge clk) disable iff (rst)
        rd0_cnt <= 8'(RESET_TRIES));

    a_r5_aneg_poll_bound: assert property (@(posedge clk) disable iff (rst)
        rd1_cnt <= 8'(ANEG_TRIES + 1));
endmodule

bind phy_bringup_seq phy_bringup_seq_chk #(
    .RESET_TRIES (RESET_TRIES),
    .ANEG_TRIES  (ANEG_TRIES)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .done          (done),
    .err_code      (err_code),
    .speed_100     (speed_100),
    .full_duplex   (full_duplex),
    .mdio_req      (mdio_req),
    .mdio_write    (mdio_write),
    .mdio_reg_addr (mdio_reg_addr),
    .mdio_wdata    (mdio_wdata),
    .mdio_ack      (mdio_ack)
);

// File: tb/phy_bringup_seq_tb.sv
module phy_bringup_seq_tb;
    localparam int         CLK_PERIOD = 10;
    localparam int         T_GAP      = 2;
    localparam int         T_RTRIES   = 4;
    localparam int         T_ATRIES   = 5;
    localparam logic [4:0] T_ADDR     = 5'd3;
    localparam int         ACK_LAT    = 3;

    typedef struct packed {
        logic [3:0]  rb;
        logic [3:0]  ab;
        logic [15:0] st;
        logic [1:0]  err;
        logic        sp;
        logic        dp;
        logic [3:0]  rd0;
        logic [3:0]  rd1;
        logic [1:0]  wr;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{rb:4'd0, ab:4'd0, st:16'h4000, err:2'd0, sp:1'b1, dp:1'b1, rd0:4'd1, rd1:4'd2, wr:2'd3},
        '{rb:4'd2, ab:4'd3, st:16'h2000, err:2'd0, sp:1'b1, dp:1'b0, rd0:4'd3, rd1:4'd5, wr:2'd3},
        '{rb:4'd3, ab:4'd0, st:16'h1000, err:2'd0, sp:1'b0, dp:1'b1, rd0:4'd4, rd1:4'd2, wr:2'd3},
        '{rb:4'd0, ab:4'd4, st:16'h0800, err:2'd0, sp:1'b0, dp:1'b0, rd0:4'd1, rd1:4'd6, wr:2'd3},
        '{rb:4'd4, ab:4'd0, st:16'h4000, err:2'd1, sp:1'b0, dp:1'b0, rd0:4'd4, rd1:4'd0, wr:2'd1},
        '{rb:4'd1, ab:4'd5, st:16'h4000, err:2'd2, sp:1'b0, dp:1'b0, rd0:4'd2, rd1:4'd5, wr:2'd3},
        '{rb:4'd0, ab:4'd1, st:16'h7000, err:2'd0, sp:1'b1, dp:1'b1, rd0:4'd1, rd1:4'd3, wr:2'd3},
        '{rb:4'd9, ab:4'd0, st:16'h2000, err:2'd1, sp:1'b0, dp:1'b0, rd0:4'd4, rd1:4'd0, wr:2'd1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        done;
    logic [1:0]  err_code;
    logic        speed_100, full_duplex;
    logic        mdio_req, mdio_write;
    logic [4:0]  mdio_phy_addr, mdio_reg_addr;
    logic [15:0] mdio_wdata;
    logic        mdio_ack = 1'b0;
    logic [15:0] mdio_rdata = 16'h0;

    int checks = 0;
    int fails  = 0;

    // PHY model configuration and observations
    logic        model_clr = 1'b0;
    logic [3:0]  cfg_rb = '0, cfg_ab = '0;
    logic [15:0] cfg_st = '0;
    int          rd0_n, rd1_n, wr_n;
    logic        wr_bad, addr_bad, overlap;
    logic        pend;
    int          lat;
    logic [15:0] resp;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_bringup_seq #(
        .POLL_GAP    (T_GAP),
        .RESET_TRIES (T_RTRIES),
        .ANEG_TRIES  (T_ATRIES),
        .PHY_ADDR    (T_ADDR)
    ) u_dut (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .done          (done),
        .err_code      (err_code),
        .speed_100     (speed_100),
        .full_duplex   (full_duplex),
        .mdio_req      (mdio_req),
        .mdio_write    (mdio_write),
        .mdio_phy_addr (mdio_phy_addr),
        .mdio_reg_addr (mdio_reg_addr),
        .mdio_wdata    (mdio_wdata),
        .mdio_ack      (mdio_ack),
        .mdio_rdata    (mdio_rdata)
    );

    function automatic logic [20:0] exp_write(input int idx);
        case (idx)
            0:       return {5'd0, 16'h8000};
            1:       return {5'd4, 16'h01E1};
            2:       return {5'd0, 16'h1200};
            default: return 21'h1FFFFF;
        endcase
    endfunction

    // Behavioural PHY behind the management master
    always @(posedge clk) begin
        mdio_ack <= 1'b0;
        if (model_clr) begin
            rd0_n <= 0; rd1_n <= 0; wr_n <= 0;
            wr_bad <= 1'b0; addr_bad <= 1'b0; overlap <= 1'b0;
            pend <= 1'b0; lat <= 0;
        end else if (mdio_req) begin
            if (pend) overlap <= 1'b1;
            pend <= 1'b1;
            lat  <= ACK_LAT;
            if (mdio_phy_addr != T_ADDR) addr_bad <= 1'b1;
            if (mdio_write) begin
                if ({mdio_reg_addr, mdio_wdata} != exp_write(wr_n)) wr_bad <= 1'b1;
                wr_n <= wr_n + 1;
                resp <= 16'h0;
            end else if (mdio_reg_addr == 5'd0) begin
                resp  <= (rd0_n < int'(cfg_rb)) ? 16'h9100 : 16'h1100;
                rd0_n <= rd0_n + 1;
            end else begin
                resp  <= (rd1_n < int'(cfg_ab)) ? (cfg_st & ~16'h0020) : (cfg_st | 16'h0020);
                rd1_n <= rd1_n + 1;
            end
        end else if (pend) begin
            if (lat == 1) begin
                mdio_ack   <= 1'b1;
                mdio_rdata <= resp;
                pend       <= 1'b0;
            end
            lat <= lat - 1;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Runs one bring-up; poke=1 pulses start repeatedly mid-run (R10)
    task automatic run_one(input vec_t v, input bit poke, input string name);
        int n = 0;
        int dcount = 0;
        int extra = 0;
        cfg_rb = v.rb; cfg_ab = v.ab; cfg_st = v.st;
        model_clr = 1'b1;
        @(negedge clk);
        model_clr = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
            start = poke && (n % 7 == 3);
        end
        start = 1'b0;
        if (!done) begin
            check({name, " R8 watchdog"}, 0, 1);
            return;
        end
        dcount = 1;
        check({name, " R8 err_code"}, int'(err_code), int'(v.err));
        check({name, " R6 speed_100"}, int'(speed_100), int'(v.sp));
        check({name, " R7 full_duplex"}, int'(full_duplex), int'(v.dp));
        repeat (8) begin
            @(negedge clk);
            if (done) dcount++;
            if (mdio_req) extra++;
        end
        check({name, " R8 done count"}, dcount, 1);
        check({name, " R3 idle after run"}, extra, 0);
        check({name, " R3 reg0 reads"}, rd0_n, int'(v.rd0));
        check({name, " R5 reg1 reads"}, rd1_n, int'(v.rd1));
        check({name, " R4 write count"}, wr_n, int'(v.wr));
        check({name, " R2 R4 write order"}, int'(wr_bad), 0);
        check({name, " R2 phy address"}, int'(addr_bad), 0);
        check({name, " R9 overlap"}, int'(overlap), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 done", int'(done), 0);
        check("R1 mdio_req", int'(mdio_req), 0);
        check("R1 err_code", int'(err_code), 0);
        check("R1 speed_100", int'(speed_100), 0);
        check("R1 full_duplex", int'(full_duplex), 0);

        for (int i = 0; i < NV; i++) begin
            run_one(VECS[i], 1'b0, $sformatf("vec%0d", i));
        end

        // R10: start pulses during a run change nothing
        run_one(VECS[1], 1'b1, "busy_start R10");
        run_one(VECS[5], 1'b1, "busy_start_err R10");

        // Outputs hold after a run until the next start
        repeat (20) @(negedge clk);
        check("R8 hold err_code", int'(err_code), 2);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule